// File: doc/BRIEF.md
# Parallel-Bank Matrix Multiply Engine

This block multiplies two square integer matrices, P × Q, and streams out every element of the product, one element per clock cycle. Both operands are written in through their own write ports as flat word arrays. The left operand's flat address is `row*N + inner`. The right operand's flat address is `inner*N + col`. Each operand is spread over N small memory banks. The left operand is interleaved by the low address bits, so each inner index has its own bank. The right operand is cut into contiguous chunks selected by the high address bits, so again each inner index has its own bank. One read of every bank therefore delivers a full row of P and a full column of Q in a single cycle.

A one-cycle `start` pulse launches a pass. A sequencer walks through every (row, col) pair, one pair per cycle, with the column index changing fastest. For each pair, N multipliers and a registered adder tree of depth log2(N) form the dot product. Each result leaves the block with its row and column index and a valid flag. `done` pulses once the final element has been emitted.

Top module: `mm_engine`

## Requirements
- R1: After reset, and until the first `start`, `c_valid` and `done` are low.
- R2: A write to the left port at address `i*N+k` sets P[i][k]. A write to the right port at address `k*N+j` sets Q[k][j]. Both addresses are 2·log2(N) bits wide. Stored words persist across passes.
- R3: Each output value equals the sum over k of P[i][k]·Q[k][j], computed in W-bit two's complement with wraparound (modulo 2^W).
- R4: Count the rising edge that samples `start` as edge 1. The first output is valid after rising edge 3+log2(N).
- R5: One pass emits exactly N·N outputs, on consecutive cycles with no gaps. Nothing more is emitted until the next `start`.
- R6: Outputs come in row-major order, starting at (0,0). `c_col` increments every element, and `c_row` increments when `c_col` wraps from N-1 to 0.
- R7: `done` is high for exactly one cycle: the cycle right after the one that carries element (N-1, N-1).
- R8: A `start` pulse that arrives while the pass is still issuing pairs is ignored. The running pass is neither restarted nor lengthened.
- R9: Rewriting some words of one operand between passes changes the next pass's results according to R3, using the new words and the untouched old ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_we | input | 1 | Left operand write enable |
| a_addr | input | 2·log2(N) | Left operand flat address, row*N+inner |
| a_wdata | input | W | Left operand write data |
| b_we | input | 1 | Right operand write enable |
| b_addr | input | 2·log2(N) | Right operand flat address, inner*N+col |
| b_wdata | input | W | Right operand write data |
| start | input | 1 | One-cycle launch pulse |
| c_valid | output | 1 | Output element valid |
| c_row | output | log2(N) | Row index of the output element |
| c_col | output | log2(N) | Column index of the output element |
| c_data | output | W | Output element value |
| done | output | 1 | One-cycle pulse after the final element |

## Verification
The bench uses an identity right operand to expose swapped bank selects. A wrong interleave on either operand would permute or transpose the result instead of reproducing P. All-ones and sign-bit operands force every product and partial sum to wrap; a tree that carried extra bits or saturated would return the wrong low word. A second `start` is injected while a pass is issuing. A sequencer that honoured it would restart from (0,0), producing more than N·N outputs, out-of-order indices and a late `done`. Latency is checked against the exact edge count, so a missing or extra pipeline register in the read, multiply or tree stages shifts the first valid cycle and is reported.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic {SEQ_IDLE, SEQ_ISSUE} seq_state_e;
endpackage

// File: rtl/mm_bank.sv
module mm_bank #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int DW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [DW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [DW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // one write port, one registered read port: RAM-inferable
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mm_seq.sv
module mm_seq
  import mm_pkg::*;
#(
  parameter int N   = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          issue,
  output logic [IW-1:0] row,
  output logic [IW-1:0] col,
  output logic          last
);
  seq_state_e state;
  logic       at_end;

  assign at_end = (row == IW'(N-1)) && (col == IW'(N-1));
  assign issue  = (state == SEQ_ISSUE);
  assign last   = issue && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
      row   <= '0;
      col   <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (start) begin
          state <= SEQ_ISSUE;
          row   <= '0;
          col   <= '0;
        end
        SEQ_ISSUE: begin
          col <= col + 1'b1;
          if (col == IW'(N-1)) row <= row + 1'b1;
          if (at_end) state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R8: a running pass never jumps back to (0,0) before it finishes
  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_ISSUE && !at_end) |=> (state == SEQ_ISSUE && (row != '0 || col != '0)));

  // R6: column advances by one every issuing cycle
  a_r6_col_step: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_ISSUE && !at_end) |=> col == IW'($past(col) + 1'b1));
endmodule

// File: rtl/mm_adder_tree.sv
module mm_adder_tree #(
  parameter int N = 8,
  parameter int W = 32
) (
  input  logic         clk,
  input  logic [W-1:0] leaf [N],
  output logic [W-1:0] sum
);
  // heap numbering: node m sums children 2m and 2m+1; children >= N are leaves
  logic [W-1:0] node_q [1:N-1];

  for (genvar m = 1; m < N; m++) begin : g_node
    logic [W-1:0] lhs, rhs;
    if (2*m >= N) begin : g_leaf_kids
      assign lhs = leaf[2*m-N];
      assign rhs = leaf[2*m+1-N];
    end else begin : g_inner_kids
      assign lhs = node_q[2*m];
      assign rhs = node_q[2*m+1];
    end
    always_ff @(posedge clk) node_q[m] <= lhs + rhs;
  end

  assign sum = node_q[1];
endmodule

// File: rtl/mm_engine.sv
module mm_engine #(
  parameter int N   = 8,
  parameter int W   = 32,
  localparam int IW = $clog2(N),
  localparam int AW = 2*IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  a_wdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [W-1:0]  b_wdata,
  input  logic          start,
  output logic          c_valid,
  output logic [IW-1:0] c_row,
  output logic [IW-1:0] c_col,
  output logic [W-1:0]  c_data,
  output logic          done
);
  localparam int LVL   = IW;
  localparam int DEPTH = 2 + LVL; // bank read, product, tree levels

  logic          iss, iss_last;
  logic [IW-1:0] s_row, s_col;
  logic [W-1:0]  a_q [N];
  logic [W-1:0]  b_q [N];
  logic [W-1:0]  prod_q [N];

  mm_seq #(.N(N)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .issue(iss), .row(s_row), .col(s_col), .last(iss_last)
  );

  for (genvar k = 0; k < N; k++) begin : g_lane
    // left operand: interleaved, bank = low bits (inner), word = high bits (row)
    mm_bank #(.W(W), .DEPTH(N)) u_abank (
      .clk(clk),
      .we(a_we && (a_addr[IW-1:0] == IW'(k))),
      .waddr(a_addr[AW-1:IW]), .wdata(a_wdata),
      .raddr(s_row), .rdata(a_q[k])
    );
    // right operand: chunked, bank = high bits (inner), word = low bits (col)
    mm_bank #(.W(W), .DEPTH(N)) u_bbank (
      .clk(clk),
      .we(b_we && (b_addr[AW-1:IW] == IW'(k))),
      .waddr(b_addr[IW-1:0]), .wdata(b_wdata),
      .raddr(s_col), .rdata(b_q[k])
    );
    always_ff @(posedge clk) prod_q[k] <= a_q[k] * b_q[k];
  end

  mm_adder_tree #(.N(N), .W(W)) u_tree (
    .clk(clk), .leaf(prod_q), .sum(c_data)
  );

  // tag pipeline travelling beside the data path
  logic [DEPTH-1:0] v_pipe, l_pipe;
  logic [IW-1:0]    r_pipe [DEPTH];
  logic [IW-1:0]    k_pipe [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_pipe <= '0;
      l_pipe <= '0;
      done   <= 1'b0;
    end else begin
      v_pipe <= {v_pipe[DEPTH-2:0], iss};
      l_pipe <= {l_pipe[DEPTH-2:0], iss_last};
      done   <= v_pipe[DEPTH-1] && l_pipe[DEPTH-1];
    end
    r_pipe[0] <= s_row;
    k_pipe[0] <= s_col;
    for (int s = 1; s < DEPTH; s++) begin
      r_pipe[s] <= r_pipe[s-1];
      k_pipe[s] <= k_pipe[s-1];
    end
  end

  assign c_valid = v_pipe[DEPTH-1];
  assign c_row   = r_pipe[DEPTH-1];
  assign c_col   = k_pipe[DEPTH-1];

  // R5: stream has no gaps until the final element
  a_r5_contiguous: assert property (@(posedge clk) disable iff (rst)
    (c_valid && !(c_row == IW'(N-1) && c_col == IW'(N-1))) |=> c_valid);

  // R6: row-major order on the output
  a_r6_row_major: assert property (@(posedge clk) disable iff (rst)
    (c_valid && c_col != IW'(N-1)) |=>
      (c_col == IW'($past(c_col) + 1'b1) && c_row == $past(c_row)));

  // R7: done follows the final element and lasts one cycle
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(c_valid && c_row == IW'(N-1) && c_col == IW'(N-1)));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/mm_engine_tb_top.sv
`timescale 1ns/1ps
module mm_engine_tb_top;
  localparam int N  = 8;
  localparam int W  = 32;
  localparam int IW = $clog2(N);
  localparam int AW = 2*IW;
  localparam int LAT = 3 + IW;

  logic clk = 1'b0;
  logic rst;
  logic a_we, b_we, start;
  logic [AW-1:0] a_addr, b_addr;
  logic [W-1:0]  a_wdata, b_wdata;
  logic c_valid, done;
  logic [IW-1:0] c_row, c_col;
  logic [W-1:0]  c_data;

  logic [W-1:0] mp [N][N];
  logic [W-1:0] mq [N][N];
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  mm_engine #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst(rst),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .start(start), .c_valid(c_valid), .c_row(c_row), .c_col(c_col),
    .c_data(c_data), .done(done)
  );

  function automatic logic [W-1:0] ref_elem(int i, int j);
    logic [W-1:0] acc = '0;
    for (int k = 0; k < N; k++) acc = acc + mp[i][k] * mq[k][j];
    return acc;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load_all();
    for (int idx = 0; idx < N*N; idx++) begin
      @(negedge clk);
      a_we = 1'b1; a_addr = AW'(idx); a_wdata = mp[idx/N][idx%N];
      b_we = 1'b1; b_addr = AW'(idx); b_wdata = mq[idx/N][idx%N];
    end
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
  endtask

  task automatic run_pass(bit inject_start, string tag);
    int seen = 0;
    bit done_seen = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int cyc = 1; cyc <= LAT + N*N + 8; cyc++) begin
      if (c_valid) begin
        if (seen == 0) check(cyc == LAT, "R4", {tag, " first valid cycle"}, cyc, LAT);
        check(cyc == LAT + seen, "R5", {tag, " gapless cycle"}, cyc, LAT + seen);
        check(c_row == IW'(seen / N) && c_col == IW'(seen % N), "R6",
              {tag, " index"}, {c_row, c_col}, {IW'(seen / N), IW'(seen % N)});
        if (seen < N*N)
          check(c_data == ref_elem(seen / N, seen % N), "R3", {tag, " value"},
                c_data, ref_elem(seen / N, seen % N));
        seen++;
      end
      if (done) begin
        check(cyc == LAT + N*N && !done_seen, "R7", {tag, " done cycle"}, cyc, LAT + N*N);
        done_seen = 1'b1;
      end
      start = (inject_start && cyc == 10); // R8: mid-pass start
      @(negedge clk);
    end
    start = 1'b0;
    check(seen == N*N, "R5", {tag, " element count"}, seen, N*N);
    check(done_seen, "R7", {tag, " done seen"}, done_seen, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog expired: actual hang expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; start = 1'b0; a_we = 1'b0; b_we = 1'b0;
    a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
    repeat (3) @(negedge clk);
    check(!c_valid && !done, "R1", "outputs in reset", {c_valid, done}, 0);
    rst = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      check(!c_valid && !done, "R1", "idle after reset", {c_valid, done}, 0);
    end

    // random operands, with a start injected mid-pass (R2, R3, R8)
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        mp[i][j] = $urandom;
        mq[i][j] = $urandom;
      end
    load_all();
    run_pass(1'b1, "R8 random");

    // identity right operand: result must reproduce P exactly (R2)
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) mq[i][j] = (i == j) ? 32'd1 : 32'd0;
    load_all();
    run_pass(1'b0, "R2 identity");

    // wraparound corners: all ones and sign-bit words (R3)
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        mp[i][j] = (j % 2 == 0) ? 32'hFFFF_FFFF : 32'h8000_0000;
        mq[i][j] = (i % 3 == 0) ? 32'hFFFF_FFFF : 32'h7FFF_FFFF + W'(j);
      end
    load_all();
    run_pass(1'b0, "R3 wrap");

    // rewrite a few left words only; right operand keeps its contents (R9)
    for (int n = 0; n < 5; n++) begin
      int idx = int'($urandom_range(N*N-1, 0));
      mp[idx/N][idx%N] = $urandom;
      @(negedge clk);
      a_we = 1'b1; a_addr = AW'(idx); a_wdata = mp[idx/N][idx%N];
    end
    @(negedge clk) a_we = 1'b0;
    run_pass(1'b0, "R9 partial reload");

    repeat (4) @(negedge clk);
    check(!c_valid && !done, "R5", "quiet after passes", {c_valid, done}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule